// File: doc/BRIEF.md
# Clock-Enable Prescaler with Hold Control

The block turns the system clock into a periodic single-cycle enable pulse for timer channels. A first stage divides the clock by two or by three. Each terminal pulse of that stage advances a 6-bit binary counter. One of four counter taps then sets the rate of the enable output. Software controls the prescaler through a bank of four 16-bit register locations: a control word, a test word kept only as storage, and two reserved words. The bank is reached through a synchronous port with a 3-bit word offset, a write strobe, 16-bit write data and registered 16-bit read data.

A hold input (`frz_i`) suspends all counting. Both the first stage and the binary counter keep their values while it is high. When it falls they continue from where they stopped, so the only effect is a delay equal to the number of held cycles. The register bank stays fully usable during a hold. Clearing the run bit stops the prescaler and zeroes it, so the next start always begins from a known phase.

The first stage is a state machine with four states. `ST_IDLE` means stopped, and `ST_PH0`, `ST_PH1` and `ST_PH2` are the phases of one division cycle. Its transitions are as follows:
- start: `ST_IDLE`→`ST_PH0` when run is set.
- advance: `ST_PH0`→`ST_PH1`.
- wrap2: `ST_PH1`→`ST_PH0` when dividing by two. This transition emits a stage pulse.
- extend: `ST_PH1`→`ST_PH2` when dividing by three.
- wrap3: `ST_PH2`→`ST_PH0`. This transition emits a stage pulse.
- stop: any state→`ST_IDLE` when run is clear.
- hold: the state is kept while `frz_i` is high and run is set.

Top module: `tick_prescaler`

## Requirements
- R1: After reset the control word and the test word read 0x0000, and `tick_o` stays low.
- R2: The control word is at word offset 4 and the test word is at offset 5. The test word is a full 16-bit read/write store. Offsets 6, 7 and 0 to 3 read 0x0000, and writes to them change no other register. Read data appears on `reg_rdata_o` in the cycle after the offset is presented.
- R3: The control word has three fields: run at bit 7, divide-by-three select at bit 6, and tap select at bits 1:0. All other bits read 0, so writing 0xFFFF reads back 0x00C3.
- R4: The first stage divides by 2 when bit 6 is 0 and by 3 when bit 6 is 1.
- R5: The tap select sets the pulse period to d×m clock cycles. Here d is the first-stage divisor and m is 1, 4, 16 or 64 for tap codes 00, 01, 10 and 11.
- R6: Take the clock edge that writes run=1 from a cleared state. `tick_o` is first high in the (1 + d×m)-th cycle after that edge.
- R7: `tick_o` is high for exactly one cycle at a time. It is never high while run is 0 or `frz_i` is 1.
- R8: If `frz_i` is high for F clock edges, the counter state and the first-stage state do not change over those edges. Counting then resumes from the held values, so the next pulse is delayed by exactly F cycles.
- R9: While `frz_i` is high, both registers can still be read and written with normal timing.
- R10: Clearing run stops and zeroes the prescaler. Setting run again restarts from zero, and the first pulse again follows the R6 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frz_i | input | 1 | Hold request; suspends counting |
| reg_addr_i | input | 3 | Register word offset |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Registered read data |
| tick_o | output | 1 | Prescaled single-cycle enable pulse |

## Verification
A hold and a register access can occur in the same cycle. A hold and an expected output pulse can also coincide. The bench raises `frz_i` in three places: on the very cycle the run bit is written, in the middle of a count, and shortly before a long-period pulse falls due. During one of these holds it reads the control word and writes and reads the test word. Each case passes only if the first pulse lands exactly F cycles later than the computed latency, no pulse appears while the hold is sampled high, and every register access returns the stored value on the cycle after it is issued.

// File: rtl/psc_pkg.sv
package psc_pkg;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_TEST = 3'd5;

    localparam int RUN_POS = 7;
    localparam int DIV_POS = 6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH0  = 2'd1,
        ST_PH1  = 2'd2,
        ST_PH2  = 2'd3
    } stage_e;

    typedef struct packed {
        logic       run;
        logic       div3;
        logic [1:0] tap;
    } ctrl_t;
endpackage

// File: rtl/psc_regs.sv
module psc_regs
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output ctrl_t             ctrl_o
);
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] test_q;
    logic [DATA_W-1:0] rd_mux;
    logic              hit_ctrl, hit_test;

    assign hit_ctrl = (addr_i == OFS_CTRL);
    assign hit_test = (addr_i == OFS_TEST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            test_q <= '0;
        end else if (we_i) begin
            if (hit_ctrl) begin
                ctrl_q.run  <= wdata_i[RUN_POS];
                ctrl_q.div3 <= wdata_i[DIV_POS];
                ctrl_q.tap  <= wdata_i[1:0];
            end
            if (hit_test) test_q <= wdata_i;
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[RUN_POS] = ctrl_q.run;
            rd_mux[DIV_POS] = ctrl_q.div3;
            rd_mux[1:0]     = ctrl_q.tap;
        end else if (hit_test) begin
            rd_mux = test_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_o <= '0;
        else        rdata_o <= rd_mux;
    end

    assign ctrl_o = ctrl_q;

    // R2: unmapped offsets read zero one cycle later
    assert_unmapped_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i != OFS_CTRL && addr_i != OFS_TEST) |=> (rdata_o == '0));
    // R2: writes outside the control offset leave the control word alone
    assert_ctrl_untouched_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i != OFS_CTRL) |=> $stable(ctrl_q));
endmodule

// File: rtl/psc_stage.sv
module psc_stage
    import psc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic div3_i,
    input  logic frz_i,
    output logic pulse_o
);
    stage_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!run_i) begin
            state_d = ST_IDLE;
        end else if (!frz_i) begin
            unique case (state_q)
                ST_IDLE: state_d = ST_PH0;
                ST_PH0:  state_d = ST_PH1;
                ST_PH1:  state_d = div3_i ? ST_PH2 : ST_PH0;
                ST_PH2:  state_d = ST_PH0;
            endcase
        end
    end

    always_comb begin
        pulse_o = 1'b0;
        if (run_i && !frz_i) begin
            unique case (state_q)
                ST_PH1:  pulse_o = !div3_i;
                ST_PH2:  pulse_o = 1'b1;
                default: pulse_o = 1'b0;
            endcase
        end
    end

    // R10: a cleared run bit parks the stage in idle
    assert_stop_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (state_q == ST_IDLE));
    // R8: hold keeps the phase
    assert_hold_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && frz_i) |=> (state_q == $past(state_q)));
    // R7: stage pulses never come back to back
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);
endmodule

// File: rtl/psc_chain.sv
module psc_chain #(
    parameter int CNT_W    = 6,
    parameter int TAP_STEP = 2,
    localparam int TAP_N   = CNT_W / TAP_STEP + 1,
    localparam int SEL_W   = $clog2(TAP_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             frz_i,
    input  logic             pulse_i,
    input  logic [SEL_W-1:0] tap_i,
    output logic             tick_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [TAP_N-1:0] tap_hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (!run_i)             cnt_q <= '0;
        else if (pulse_i && !frz_i)  cnt_q <= cnt_q + 1'b1;
    end

    for (genvar k = 0; k < TAP_N; k++) begin : g_tap
        if (k == 0) begin : g_direct
            assign tap_hit[k] = 1'b1;
        end else begin : g_masked
            assign tap_hit[k] = &cnt_q[k*TAP_STEP-1:0];
        end
    end

    assign tick_o = pulse_i && tap_hit[tap_i];

    // R8: hold freezes the binary stage
    assert_hold_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && frz_i) |=> $stable(cnt_q));
    // R10: stopping zeroes the binary stage
    assert_stop_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frz_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic              reg_we_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              tick_o
);
    ctrl_t ctrl;
    logic  stage_pulse;

    psc_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (reg_addr_i),
        .we_i    (reg_we_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .ctrl_o  (ctrl)
    );

    psc_stage u_stage (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl.run),
        .div3_i  (ctrl.div3),
        .frz_i   (frz_i),
        .pulse_o (stage_pulse)
    );

    psc_chain #(.CNT_W(6), .TAP_STEP(2)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (ctrl.run),
        .frz_i   (frz_i),
        .pulse_i (stage_pulse),
        .tap_i   (ctrl.tap),
        .tick_o  (tick_o)
    );

    // R7: no output pulse while stopped or held
    assert_tick_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> (ctrl.run && !frz_i));
    // R7: output pulse lasts one cycle
    assert_tick_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: tb/sim_tick_prescaler.sv
`timescale 1ns/1ps
module sim_tick_prescaler;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frz = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        tick;
    logic [15:0] rv;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    tick_prescaler u0 (
        .clk(clk), .rst_n(rst_n), .frz_i(frz), .reg_addr_i(addr),
        .reg_we_i(we), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .tick_o(tick)
    );

    // {div3, tap, first latency, period}
    localparam logic [18:0] VEC [8] = '{
        {1'b0, 2'd0, 8'd3,   8'd2},
        {1'b0, 2'd1, 8'd9,   8'd8},
        {1'b0, 2'd2, 8'd33,  8'd32},
        {1'b0, 2'd3, 8'd129, 8'd128},
        {1'b1, 2'd0, 8'd4,   8'd3},
        {1'b1, 2'd1, 8'd13,  8'd12},
        {1'b1, 2'd2, 8'd49,  8'd48},
        {1'b1, 2'd3, 8'd193, 8'd192}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        addr = a; wdata = d; we = 1'b1;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        addr = a;
        @(posedge clk); @(negedge clk);
        d = rdata;
    endtask

    task automatic run_case(input bit d3, input logic [1:0] sel, input int fs, input int fl,
                            input int exp_lat, input int exp_per, input string tag);
        int lat = -1;
        int per = 0;
        bit bad = 1'b0;
        wr(3'd4, 16'h0080 | (d3 ? 16'h0040 : 16'h0000) | {14'd0, sel});
        for (int n = 1; n < 700; n++) begin
            if (tick) begin lat = n; break; end
            frz = (n >= fs && n < fs + fl);
            @(negedge clk);
            if (frz && tick) bad = 1'b1;
        end
        frz = 1'b0;
        chk(lat == exp_lat, {tag, " first pulse latency"}, lat, exp_lat);
        chk(!bad, "R7 pulse while held", bad, 0);
        for (int p = 1; p < 700; p++) begin
            @(negedge clk);
            if (tick) begin per = p; break; end
            if (p == 1) chk(!tick, "R7 single-cycle pulse", tick, 0);
        end
        chk(per == exp_per, {tag, " pulse period"}, per, exp_per);
        wr(3'd4, 16'h0000);
        chk(!tick, "R10 stopped after clear", tick, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!tick, "R1 tick low in reset", tick, 0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(3'd4, rv); chk(rv == 16'h0000, "R1 control after reset", rv, 0);
        rd(3'd5, rv); chk(rv == 16'h0000, "R1 test after reset", rv, 0);
        repeat (20) begin
            @(negedge clk);
            if (tick) chk(1'b0, "R1 no tick when stopped", 1, 0);
        end

        // R2 address map
        wr(3'd5, 16'hA5C3);
        rd(3'd5, rv); chk(rv == 16'hA5C3, "R2 test word store", rv, 16'hA5C3);
        wr(3'd6, 16'hFFFF); rd(3'd6, rv); chk(rv == 0, "R2 reserved 6 reads zero", rv, 0);
        wr(3'd7, 16'hFFFF); rd(3'd7, rv); chk(rv == 0, "R2 reserved 7 reads zero", rv, 0);
        wr(3'd0, 16'hFFFF); rd(3'd0, rv); chk(rv == 0, "R2 offset 0 reads zero", rv, 0);
        rd(3'd5, rv); chk(rv == 16'hA5C3, "R2 test word kept", rv, 16'hA5C3);
        rd(3'd4, rv); chk(rv == 16'h0000, "R2 control kept", rv, 0);

        // R3 control layout
        wr(3'd4, 16'hFFFF);
        rd(3'd4, rv); chk(rv == 16'h00C3, "R3 control readback mask", rv, 16'h00C3);
        wr(3'd4, 16'h0000);
        rd(3'd4, rv); chk(rv == 16'h0000, "R3 control cleared", rv, 0);

        // R4 R5 R6: vector walk
        foreach (VEC[i]) begin
            run_case(VEC[i][18], VEC[i][17:16], 1000, 0,
                     int'(VEC[i][15:8]), int'(VEC[i][7:0]), "R4 R5 R6");
        end

        // R8: hold at start, mid-count, and near a long pulse
        run_case(1'b0, 2'd1, 1, 5, 14, 8, "R8 hold at start");
        run_case(1'b0, 2'd2, 10, 7, 40, 32, "R8 hold mid-count");
        run_case(1'b1, 2'd3, 180, 20, 213, 192, "R8 hold near pulse");

        // R9: register traffic during a hold
        wr(3'd4, 16'h0080);
        frz = 1'b1;
        rd(3'd4, rv); chk(rv == 16'h0080, "R9 read control while held", rv, 16'h0080);
        wr(3'd5, 16'h1234);
        rd(3'd5, rv); chk(rv == 16'h1234, "R9 test write while held", rv, 16'h1234);
        wr(3'd4, 16'h0081);
        rd(3'd4, rv); chk(rv == 16'h0081, "R9 control write while held", rv, 16'h0081);
        chk(!tick, "R7 no tick while held", tick, 0);
        frz = 1'b0;
        wr(3'd4, 16'h0000);

        // R10: stop mid-count, restart from zero
        wr(3'd4, 16'h0081);
        repeat (5) @(negedge clk);
        wr(3'd4, 16'h0000);
        repeat (3) @(negedge clk);
        run_case(1'b0, 2'd1, 1000, 0, 9, 8, "R10 restart from zero");

        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule